// File: doc/BRIEF.md
# Integer ALU with Carry and Overflow Flags

This block is the integer execution unit of a 32-bit processor datapath. It takes two operands, a 4-bit operation code and the current carry, condition and overflow-enable state, and returns a result, a write-enable for the destination register, the updated carry and overflow flags and a range-exception request. Addition, subtraction, bitwise logic, multiplication, conditional move and bit-scan complete one cycle after acceptance. Signed and unsigned division run on an iterative divider that produces one quotient bit per cycle.

Operations enter on a valid/ready request interface and results leave on a valid/ready response interface with a single output slot. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a division is in progress and while a result is held that the consumer has not yet taken. Back-pressure is applied with `out_ready`: while `out_valid` is high and `out_ready` is low, every response output holds its value. The flag inputs are plain control pins that are sampled with the request.

Top module: `int_alu`

## Requirements
- R1: A request is accepted when `in_valid` and `in_ready` are both high at a rising edge. A non-divide result appears with `out_valid` after that edge. While `out_valid` is high and `out_ready` is low, the result and all flag outputs hold their values.
- R2: Code 0x0 adds and code 0x1 adds with `carry_in` included. `carry_out` is the unsigned carry out of bit 31 and `ovf_out` is the two's-complement overflow.
- R3: Code 0x2 computes A minus B. `carry_out` is the unsigned borrow (1 when A < B unsigned) and `ovf_out` is the signed overflow.
- R4: Codes 0x3, 0x4 and 0x5 give bitwise AND, OR and XOR. These codes, together with 0xE and 0xF, write the result, pass `carry_in` to `carry_out` and give `ovf_out` = 0.
- R5: Code 0x6 returns the low 32 bits of the signed product. `ovf_out` is 1 when the signed product does not fit in 32 signed bits. `carry_out` is 1 when the unsigned product of the operand bit patterns needs more than 32 bits.
- R6: Code 0xB returns the low 32 bits of the unsigned product. `ovf_out` is 0 and `carry_out` flags unsigned overflow.
- R7: Code 0x9 divides signed with truncation toward zero and code 0xA divides unsigned. With a nonzero divisor the result is written with both flags 0. `busy` is high from the cycle after acceptance until the result is presented, and the result appears within 34 cycles.
- R8: A divide by zero (code 0x9 or 0xA) gives `wr_en` = 0, `carry_out` = 1 and `ovf_out` = 0.
- R9: `range_exc` is set for codes 0x0, 0x1, 0x2, 0x6 and 0xB when `ovf_out` and `ovf_en` are both 1, and for the divide codes when `carry_out` and `ovf_en` are both 1. Otherwise it is 0.
- R10: Code 0xE returns operand A when `cond_flag` is 1 and operand B when it is 0.
- R11: Code 0xF scans operand A. With `scan_last` = 0 it returns the 1-based index of the lowest set bit, and with `scan_last` = 1 the 1-based index of the highest set bit. A zero input returns 0.
- R12: Codes 0x7, 0x8, 0xC and 0xD give `wr_en` = 0, pass `carry_in` to `carry_out` and give `ovf_out` = 0 and `range_exc` = 0.
- R13: After reset `out_valid` and `busy` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B (register or extended immediate) |
| carry_in | input | 1 | Current carry flag |
| cond_flag | input | 1 | Current condition flag, selects for conditional move |
| ovf_en | input | 1 | Overflow exception enable |
| scan_last | input | 1 | Bit-scan mode: 0 lowest set bit, 1 highest set bit |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Consumer takes the response |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write enable |
| carry_out | output | 1 | Updated carry flag |
| ovf_out | output | 1 | Updated overflow flag |
| range_exc | output | 1 | Range exception request |
| busy | output | 1 | Division in progress |

## Verification
On every cycle, the assertions check the handshake: a held response stays stable, a non-divide request yields a response on the next cycle, a divide raises `busy`, and no request is accepted while `busy` is high. They also check that a range exception always comes with an overflow or carry flag, and that an overflowing result is always written. Only the bench scenarios can show the arithmetic itself. These scenarios cover carry and overflow at the word boundaries, the signed and unsigned multiply flags, the truncation of signed division, the divide-by-zero path, both bit-scan directions, and response order under random back-pressure.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADDC = 4'h1,
    OP_SUB  = 4'h2,
    OP_AND  = 4'h3,
    OP_OR   = 4'h4,
    OP_XOR  = 4'h5,
    OP_MUL  = 4'h6,
    OP_DIV  = 4'h9,
    OP_DIVU = 4'hA,
    OP_MULU = 4'hB,
    OP_CMOV = 4'hE,
    OP_SCAN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic wr;
    logic cy;
    logic ov;
    logic exc;
  } alu_flags_t;

  function automatic logic is_div_op(input logic [3:0] code);
    return (code == OP_DIV) || (code == OP_DIVU);
  endfunction

endpackage

// File: rtl/int_alu_scan.sv
module int_alu_scan #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec,
  input  logic         from_top,
  output logic [W-1:0] index
);
  localparam int IW = $clog2(W + 1);

  logic [IW-1:0] low_idx;
  logic [IW-1:0] high_idx;

  // lowest set bit: scanning down, the last hit wins
  always_comb begin
    low_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) low_idx = IW'(i + 1);
    end
  end

  // highest set bit: scanning up, the last hit wins
  always_comb begin
    high_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) high_idx = IW'(i + 1);
    end
  end

  assign index = {{(W - IW){1'b0}}, (from_top ? high_idx : low_idx)};
endmodule

// File: rtl/int_alu_arith.sv
module int_alu_arith
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         cflag,
  input  logic         ove,
  input  logic         scan_last,
  output logic [W-1:0] res,
  output alu_flags_t   flg
);
  localparam int W2 = 2 * W;

  logic [W:0]    sum_ext;
  logic [W:0]    diff_ext;
  logic          add_cin;
  logic          add_ovf;
  logic          sub_ovf;
  logic [W2-1:0] sprod;
  logic [W2-1:0] uprod;
  logic          smul_ovf;
  logic          umul_ovf;
  logic [W-1:0]  scan_idx;

  assign add_cin  = (op == OP_ADDC) ? cin : 1'b0;
  assign sum_ext  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, add_cin};
  assign diff_ext = {1'b0, a} - {1'b0, b};
  assign add_ovf  = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
  assign sub_ovf  = (a[W-1] != b[W-1]) && (diff_ext[W-1] != a[W-1]);

  assign sprod    = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
  assign uprod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  // signed fit: bits W2-1 .. W-1 all equal
  assign smul_ovf = (|sprod[W2-1:W-1]) && !(&sprod[W2-1:W-1]);
  assign umul_ovf = |uprod[W2-1:W];

  int_alu_scan #(.W(W)) u_scan (
    .vec      (a),
    .from_top (scan_last),
    .index    (scan_idx)
  );

  always_comb begin
    res     = '0;
    flg.wr  = 1'b1;
    flg.cy  = cin;
    flg.ov  = 1'b0;
    flg.exc = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADD, OP_ADDC: begin
        res    = sum_ext[W-1:0];
        flg.cy = sum_ext[W];
        flg.ov = add_ovf;
      end
      OP_SUB: begin
        res    = diff_ext[W-1:0];
        flg.cy = diff_ext[W];
        flg.ov = sub_ovf;
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_MUL: begin
        res    = sprod[W-1:0];
        flg.cy = umul_ovf;
        flg.ov = smul_ovf;
      end
      OP_MULU: begin
        res    = uprod[W-1:0];
        flg.cy = umul_ovf;
      end
      OP_CMOV: res = cflag ? a : b;
      OP_SCAN: res = scan_idx;
      default: flg.wr = 1'b0;
    endcase
    flg.exc = flg.ov && ove;
  end
endmodule

// File: rtl/int_alu_div.sv
module int_alu_div
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         ove,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output alu_flags_t   flg
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic          run_q;
  logic          done_q;
  logic [CW-1:0] step_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic          neg_q;
  logic          zero_q;
  logic          ove_q;

  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic [W:0]    trial;
  logic          fits;

  assign mag_a = (is_signed && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
  assign mag_b = (is_signed && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;

  // restoring step: one quotient bit per cycle
  assign trial = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
  assign fits  = !trial[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      ove_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        ove_q  <= ove;
        step_q <= '0;
        rem_q  <= '0;
        quo_q  <= mag_a;
        dvs_q  <= mag_b;
        neg_q  <= is_signed && (dividend[W-1] ^ divisor[W-1]);
        if (divisor == '0) begin
          zero_q <= 1'b1;
          done_q <= 1'b1;
        end else begin
          zero_q <= 1'b0;
          run_q  <= 1'b1;
        end
      end else if (run_q) begin
        rem_q  <= fits ? trial[W-1:0] : {rem_q[W-2:0], quo_q[W-1]};
        quo_q  <= {quo_q[W-2:0], fits};
        step_q <= step_q + 1'b1;
        if (step_q == CW'(W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = run_q || done_q;
  assign done     = done_q;
  assign quotient = neg_q ? (~quo_q + 1'b1) : quo_q;
  assign flg.wr   = !zero_q;
  assign flg.cy   = zero_q;
  assign flg.ov   = 1'b0;
  assign flg.exc  = zero_q && ove_q;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         carry_in,
  input  logic         cond_flag,
  input  logic         ovf_en,
  input  logic         scan_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         carry_out,
  output logic         ovf_out,
  output logic         range_exc,
  output logic         busy
);
  logic         accept;
  logic         div_req;
  logic         div_busy;
  logic         div_done;
  logic [W-1:0] div_quo;
  alu_flags_t   div_flg;
  logic [W-1:0] fast_res;
  alu_flags_t   fast_flg;
  logic         ov_q;
  logic [W-1:0] res_q;
  alu_flags_t   flg_q;

  assign in_ready = !div_busy && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign div_req  = accept && is_div_op(op);

  int_alu_arith #(.W(W)) u_arith (
    .op        (op),
    .a         (opa),
    .b         (opb),
    .cin       (carry_in),
    .cflag     (cond_flag),
    .ove       (ovf_en),
    .scan_last (scan_last),
    .res       (fast_res),
    .flg       (fast_flg)
  );

  int_alu_div #(.W(W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_req),
    .is_signed (op == OP_DIV),
    .dividend  (opa),
    .divisor   (opb),
    .ove       (ovf_en),
    .busy      (div_busy),
    .done      (div_done),
    .quotient  (div_quo),
    .flg       (div_flg)
  );

  // single response slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else if (accept && !is_div_op(op)) begin
      ov_q  <= 1'b1;
      res_q <= fast_res;
      flg_q <= fast_flg;
    end else if (div_done) begin
      ov_q  <= 1'b1;
      res_q <= div_quo;
      flg_q <= div_flg;
    end else if (out_ready) begin
      ov_q  <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign result    = res_q;
  assign wr_en     = flg_q.wr;
  assign carry_out = flg_q.cy;
  assign ovf_out   = flg_q.ov;
  assign range_exc = flg_q.exc;
  assign busy      = div_busy;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         carry_out,
  input logic         ovf_out,
  input logic         range_exc,
  input logic         busy
);
  logic div_code;
  assign div_code = (op == 4'h9) || (op == 4'hA);

  AST_HELD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(wr_en)
      && $stable(carry_out) && $stable(ovf_out) && $stable(range_exc)); // R1

  AST_FAST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !div_code |=> out_valid); // R1

  AST_DIV_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && div_code |=> busy && !out_valid); // R7

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R7

  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && range_exc |-> ovf_out || carry_out); // R9

  AST_OVERFLOW_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ovf_out |-> wr_en); // R5
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .wr_en     (wr_en),
  .carry_out (carry_out),
  .ovf_out   (ovf_out),
  .range_exc (range_exc),
  .busy      (busy)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   op = '0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         carry_in = 1'b0;
  logic         cond_flag = 1'b0;
  logic         ovf_en = 1'b0;
  logic         scan_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] result;
  logic         wr_en, carry_out, ovf_out, range_exc, busy;

  always #4 clk = ~clk;

  int_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .carry_in(carry_in), .cond_flag(cond_flag),
    .ovf_en(ovf_en), .scan_last(scan_last), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wr_en(wr_en),
    .carry_out(carry_out), .ovf_out(ovf_out), .range_exc(range_exc), .busy(busy)
  );

  typedef struct {
    logic [31:0] res;
    logic        wr, cy, ov, exc;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   bp_mode = 1'b0;

  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  function automatic exp_t model(input logic [3:0] o, input logic [31:0] x, y,
                                 input logic ci, f, ove, sl, input string tag);
    exp_t e;
    longint ss, sp, sq;
    logic [63:0] us, up;
    e.tag = tag; e.res = '0; e.wr = 1'b1; e.cy = ci; e.ov = 1'b0; e.exc = 1'b0;
    case (o)
      4'h0, 4'h1: begin
        us = {32'b0, x} + {32'b0, y} + ((o == 4'h1) ? {63'b0, ci} : 64'b0);
        ss = longint'($signed(x)) + longint'($signed(y)) + ((o == 4'h1) ? longint'(ci) : 0);
        e.res = us[31:0]; e.cy = us[32]; e.ov = (ss > SMAX) || (ss < SMIN);
      end
      4'h2: begin
        ss = longint'($signed(x)) - longint'($signed(y));
        e.res = x - y; e.cy = (x < y); e.ov = (ss > SMAX) || (ss < SMIN);
      end
      4'h3: e.res = x & y;
      4'h4: e.res = x | y;
      4'h5: e.res = x ^ y;
      4'h6, 4'hB: begin
        sp = longint'($signed(x)) * longint'($signed(y));
        up = {32'b0, x} * {32'b0, y};
        e.res = up[31:0];
        e.cy  = (up[63:32] != 0);
        e.ov  = (o == 4'h6) && ((sp > SMAX) || (sp < SMIN));
      end
      4'h9, 4'hA: begin
        e.ov = 1'b0;
        if (y == 0) begin
          e.wr = 1'b0; e.cy = 1'b1;
        end else begin
          e.cy = 1'b0;
          if (o == 4'h9) begin
            sq = longint'($signed(x)) / longint'($signed(y));
            e.res = sq[31:0];
          end else e.res = x / y;
        end
      end
      4'hE: e.res = f ? x : y;
      4'hF: begin
        for (int i = 0; i < 32; i++)
          if (!sl && x[i] && e.res == 0) e.res = i + 1;
        for (int i = 31; i >= 0; i--)
          if (sl && x[i] && e.res == 0) e.res = i + 1;
      end
      default: e.wr = 1'b0;
    endcase
    if (o == 4'h9 || o == 4'hA) e.exc = e.cy && ove;
    else if (o inside {4'h0, 4'h1, 4'h2, 4'h6, 4'hB}) e.exc = e.ov && ove;
    return e;
  endfunction

  task automatic fail_line(input string msg);
    n_bad++;
    $display("FAIL %s", msg);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic send(input logic [3:0] o, input logic [31:0] x, y,
                      input logic ci, f, ove, sl, input string tag);
    sbq.push_back(model(o, x, y, ci, f, ove, sl, tag));
    op = o; opa = x; opb = y; carry_in = ci; cond_flag = f;
    ovf_en = ove; scan_last = sl; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // back-pressure pattern
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor: compares responses in order, and held values under stall (R1)
  bit          stalled = 1'b0;
  logic [31:0] held_res;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled) begin
          n_chk++;
          if (!out_valid || result !== held_res)
            fail_line($sformatf("R1 held response: valid %b result %h expected valid 1 result %h",
                                out_valid, result, held_res));
        end
        stalled = out_valid && !out_ready;
        held_res = result;
        if (out_valid && out_ready) begin
          if (sbq.size() == 0) begin
            n_chk++;
            fail_line($sformatf("R1 unexpected response: result %h expected none", result));
          end else begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (wr_en !== e.wr || carry_out !== e.cy || ovf_out !== e.ov ||
                range_exc !== e.exc || (e.wr && result !== e.res))
              fail_line($sformatf("%s: res %h wr %b cy %b ov %b exc %b expected res %h wr %b cy %b ov %b exc %b",
                                  e.tag, result, wr_en, carry_out, ovf_out, range_exc,
                                  e.res, e.wr, e.cy, e.ov, e.exc));
          end
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL R1 watchdog: run did not complete, expected completion");
    summary();
    $finish;
  end

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic timed_div(input logic [3:0] o, input logic [31:0] x, y, input string tag);
    int cyc;
    send(o, x, y, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    n_chk++;
    if (busy !== 1'b1) fail_line($sformatf("R7 busy after divide accept: %b expected 1", busy));
    cyc = 0;
    while (!out_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    n_chk++;
    if (cyc > W + 2) fail_line($sformatf("R7 divide latency: %0d cycles expected <= %0d", cyc, W + 2));
  endtask

  initial begin
    logic [3:0] ops [12];
    ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h9, 4'hA, 4'hB, 4'hE, 4'hF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || busy !== 1'b0 || in_ready !== 1'b1)
      fail_line($sformatf("R13 reset: valid %b busy %b ready %b expected 0 0 1",
                          out_valid, busy, in_ready));

    send(4'h0, 32'd100, 32'd23, 1'b1, 1'b0, 1'b0, 1'b0, "R2 add plain");
    send(4'h0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 add unsigned carry");
    send(4'h0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 add overflow exception");
    send(4'h1, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 add with carry");
    send(4'h2, 32'd5, 32'd7, 1'b0, 1'b0, 1'b0, 1'b0, "R3 sub borrow");
    send(4'h2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 sub signed overflow");
    send(4'h3, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, "R4 and");
    send(4'h4, 32'hF000_0000, 32'h0000_000F, 1'b0, 1'b0, 1'b0, 1'b0, "R4 or");
    send(4'h5, 32'hAAAA_AAAA, 32'hFFFF_0000, 1'b1, 1'b0, 1'b0, 1'b0, "R4 xor");
    send(4'h6, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b0, 1'b1, 1'b0, "R5 mul overflow");
    send(4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R5 mul minus one squared");
    send(4'h6, 32'hFFFF_FFFE, 32'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R5 mul negative");
    send(4'hB, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b0, 1'b1, 1'b0, "R6 mulu overflow no exception");
    send(4'hB, 32'd1234, 32'd5678, 1'b1, 1'b0, 1'b0, 1'b0, "R6 mulu small");
    send(4'hE, 32'h1111_1111, 32'h2222_2222, 1'b0, 1'b1, 1'b0, 1'b0, "R10 cmov flag set");
    send(4'hE, 32'h1111_1111, 32'h2222_2222, 1'b0, 1'b0, 1'b0, 1'b0, "R10 cmov flag clear");
    send(4'hF, 32'h0000_00F0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 scan lowest");
    send(4'hF, 32'h0000_00F0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R11 scan highest");
    send(4'hF, 32'h0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R11 scan zero");
    send(4'hF, 32'h8000_0001, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R11 scan top bit");
    send(4'h7, 32'd9, 32'd9, 1'b1, 1'b0, 1'b1, 1'b0, "R12 unused code 7");
    send(4'hC, 32'd9, 32'd9, 1'b0, 1'b0, 1'b1, 1'b0, "R12 unused code C");
    drain();

    timed_div(4'h9, 32'hFFFF_FFF9, 32'd2, "R7 signed divide truncates");
    timed_div(4'h9, 32'd7, 32'hFFFF_FFFE, "R7 signed divide negative divisor");
    timed_div(4'hA, 32'hFFFF_FFFF, 32'd3, "R7 unsigned divide");
    drain();
    send(4'h9, 32'd50, 32'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 divide by zero exception");
    send(4'hA, 32'd50, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 unsigned divide by zero");
    send(4'h9, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R7 most negative by minus one");
    drain();

    bp_mode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [3:0]  o;
      logic [31:0] x, y;
      o = ops[$urandom % 12];
      x = $urandom;
      y = (($urandom % 4) == 0) ? ($urandom % 16) : $urandom;
      send(o, x, y, 1'(($urandom % 2)), 1'(($urandom % 2)), 1'(($urandom % 2)),
           1'(($urandom % 2)), "R1 burst under back-pressure");
    end
    drain();
    bp_mode = 1'b0;
    drain();

    summary();
    $finish;
  end
endmodule